// File: doc/BRIEF.md
# Temperature-aware supply voltage controller

This block chooses the supply voltage for a logic domain that runs faster when it is warm. Software programs the model coefficients once over an APB slave port. For each decision it writes the present die temperature, the converter output current and the supply setting now in force, and then sets the start bit. The controller evaluates a cubic polynomial of temperature to get the lowest safe voltage code, the candidate. It then decides whether to move the supply to that candidate and drives the chosen code on `vdd_cmd`.

A candidate above the present setting means the die has cooled. The controller then raises the supply at once and skips any efficiency test. A candidate below the present setting must pass two ordered tests before it is used. First, a linear saving estimate at the candidate must be larger than the same estimate at the present voltage. Second, that saving must still come out ahead after the converter loss is subtracted. The loss is the product of a loss coefficient, the converter current and the candidate code. When the candidate is approved, the output is first parked a margin above the candidate, never above the present setting. It then moves down one code at a time, one step every `HOLD` cycles, until it reaches the candidate.

All voltages are integer codes, one code per 0.05 V converter step.

Top module: `tvc_ctrl`

## Requirements
- R1: The APB port completes every transfer with no wait state. Byte offsets: 0x00 control (bit0 start, write-one; bit1 interrupt enable), 0x04 status (bit0 busy, bit1 done, bit2 switched), 0x08 temperature (8-bit two's complement, °C), 0x0C converter current (8-bit), 0x10 present code, 0x14 commanded code (read-only), 0x18 margin, 0x1C/0x20/0x24/0x28 polynomial coefficients c0..c3, 0x2C saving offset A, 0x30 saving temperature slope B, 0x34 saving voltage slope G, 0x38 loss coefficient K. Coefficients are 16-bit two's complement, K is unsigned, and reads return the fields zero-extended. After reset, status reads 0 and the commanded code equals VMAX.
- R2: The temperature is clamped to the range −40..80 before it is used.
- R3: The candidate is ceil((c3·T³ + c2·T² + c1·T + c0) / 2^FRAC), clamped to VMIN..VMAX.
- R4: A candidate above the present code is applied directly, with switched=1 and no comparisons.
- R5: A candidate equal to the present code leaves the output at the present code, with switched=0.
- R6: A lower candidate is examined further only if S(cand) > S(present), where S(V) = A + B·T − G·V. Otherwise the present code is applied with switched=0.
- R7: A lower candidate that passed R6 is applied only if S(cand) − K·I·cand > S(present), where I is the converter current. Otherwise the present code is applied with switched=0.
- R8: When an approved candidate lowers the output, the output first takes min(present, cand + margin). It then drops by exactly one code every HOLD cycles until it equals the candidate, and it never goes below the candidate.
- R9: Busy reads 1 from the start write until the decision completes. Done is then set and switched shows the outcome. A start write while busy is ignored.
- R10: `irq` is high while done and interrupt enable are both set. Any write to status clears done.
- R11: `vdd_cmd` changes only while a decision is in progress. Register writes while idle leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB and core clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | AW | APB byte address |
| pwdata | input | DW | APB write data |
| prdata | output | DW | APB read data |
| pready | output | 1 | APB ready, always high |
| vdd_cmd | output | VW | Commanded supply code |
| irq | output | 1 | Decision-complete interrupt |

## Verification
The bench sweeps temperatures across the full range and past both ends, with three coefficient sets and a range of present codes and converter currents, so that the candidate clamps at both ends and every decision branch is taken. A controller that truncates instead of rounding up would pick a voltage below the safe floor. One that skipped the raise path would leave a cooled die underpowered, and one that dropped the loss test would approve lowerings that cost more in the converter than they save. A monitor on `vdd_cmd` catches a ramp that jumps, dwells for the wrong time or undershoots. Directed runs check that a second start during a decision does not restart it with new inputs, and that a status write clears the interrupt.

// File: rtl/tvc_pkg.sv
package tvc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_EVAL, ST_CMP1, ST_LOSS, ST_CMP2, ST_RAMP, ST_DONE
   } tvc_state_t;

   localparam logic [7:0] OFF_CTRL   = 8'h00;
   localparam logic [7:0] OFF_STAT   = 8'h04;
   localparam logic [7:0] OFF_TEMP   = 8'h08;
   localparam logic [7:0] OFF_ISC    = 8'h0C;
   localparam logic [7:0] OFF_VCUR   = 8'h10;
   localparam logic [7:0] OFF_VCMD   = 8'h14;
   localparam logic [7:0] OFF_MARGIN = 8'h18;
   localparam logic [7:0] OFF_POLY   = 8'h1C;
   localparam logic [7:0] OFF_SA     = 8'h2C;
   localparam logic [7:0] OFF_SB     = 8'h30;
   localparam logic [7:0] OFF_SG     = 8'h34;
   localparam logic [7:0] OFF_LK     = 8'h38;
endpackage

// File: rtl/tvc_poly.sv
module tvc_poly #(
   parameter int TW   = 8,
   parameter int CW   = 16,
   parameter int VW   = 5,
   parameter int FRAC = 6,
   parameter int VMIN = 8,
   parameter int VMAX = 14
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go,
   input  logic signed [TW-1:0] t,
   input  logic signed [CW-1:0] coef [4],
   output logic                 vld,
   output logic [VW-1:0]        code
);
   localparam int ACC_W = CW + 3*TW + 2;
   localparam logic signed [ACC_W-1:0] V_LO = ACC_W'(VMIN);
   localparam logic signed [ACC_W-1:0] V_HI = ACC_W'(VMAX);
   localparam logic signed [ACC_W-1:0] RND  = ACC_W'((2**FRAC) - 1);

   logic signed [ACC_W-1:0] acc;
   logic signed [ACC_W-1:0] rnd;
   logic [1:0]              idx;
   logic                    run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         idx <= '0;
         run <= 1'b0;
         vld <= 1'b0;
      end else begin
         vld <= 1'b0;
         if (go) begin
            acc <= ACC_W'(coef[3]);
            idx <= 2'd3;
            run <= 1'b1;
         end else if (run) begin
            acc <= acc * ACC_W'(t) + ACC_W'(coef[idx - 2'd1]);
            idx <= idx - 2'd1;
            if (idx == 2'd1) begin
               run <= 1'b0;
               vld <= 1'b1;
            end
         end
      end
   end

   // round up towards the safe side, then clamp to the legal code range
   always_comb begin
      rnd = (acc + RND) >>> FRAC;
      if (rnd < V_LO)      code = VW'(VMIN);
      else if (rnd > V_HI) code = VW'(VMAX);
      else                 code = rnd[VW-1:0];
   end
endmodule

// File: rtl/tvc_ramp.sv
module tvc_ramp #(
   parameter int VW   = 5,
   parameter int VRST = 14,
   parameter int HOLD = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [VW-1:0] cur,
   input  logic [VW-1:0] tgt,
   input  logic [VW-1:0] margin,
   output logic [VW-1:0] cmd,
   output logic          fin
);
   logic [VW-1:0] tgt_q;
   logic          act;
   logic          step_en;
   logic [VW:0]   parked;

   assign parked = {1'b0, tgt} + {1'b0, margin};
   assign fin    = act && (cmd == tgt_q);

   generate
      if (HOLD <= 1) begin : g_fast
         assign step_en = act;
      end else begin : g_hold
         localparam int HW = $clog2(HOLD);
         logic [HW-1:0] hc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                hc <= '0;
            else if (go || step_en)    hc <= '0;
            else if (act)              hc <= hc + 1'b1;
         end
         assign step_en = act && (hc == HW'(HOLD - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd   <= VW'(VRST);
         tgt_q <= VW'(VRST);
         act   <= 1'b0;
      end else if (go) begin
         tgt_q <= tgt;
         act   <= 1'b1;
         if (tgt >= cur)                cmd <= tgt;
         else if (parked > {1'b0, cur}) cmd <= cur;
         else                           cmd <= parked[VW-1:0];
      end else if (fin) begin
         act <= 1'b0;
      end else if (step_en) begin
         cmd <= cmd - 1'b1;
      end
   end
endmodule

// File: rtl/tvc_ctrl.sv
module tvc_ctrl #(
   parameter int AW   = 8,
   parameter int DW   = 32,
   parameter int TW   = 8,
   parameter int CW   = 16,
   parameter int IW   = 8,
   parameter int VW   = 5,
   parameter int FRAC = 6,
   parameter int VMIN = 8,
   parameter int VMAX = 14,
   parameter int TMIN = -40,
   parameter int TMAX = 80,
   parameter int HOLD = 4
) (
   input  logic          pclk,
   input  logic          presetn,
   input  logic          psel,
   input  logic          penable,
   input  logic          pwrite,
   input  logic [AW-1:0] paddr,
   input  logic [DW-1:0] pwdata,
   output logic [DW-1:0] prdata,
   output logic          pready,
   output logic [VW-1:0] vdd_cmd,
   output logic          irq
);
   import tvc_pkg::*;

   localparam int SW = CW + IW + VW + 4;
   localparam logic signed [TW-1:0] T_LO = TW'(TMIN);
   localparam logic signed [TW-1:0] T_HI = TW'(TMAX);

   generate
      if (VMAX >= 2**VW)       begin : g_bad_vw   $error("VMAX does not fit VW"); end
      if (VMIN > VMAX)         begin : g_bad_vr   $error("VMIN above VMAX"); end
      if (FRAC >= CW)          begin : g_bad_fr   $error("FRAC too wide"); end
      if (TMAX >= 2**(TW-1))   begin : g_bad_tw   $error("TMAX does not fit TW"); end
      if (TMIN >= TMAX)        begin : g_bad_tr   $error("empty temperature range"); end
      if (AW < 8 || DW < CW)   begin : g_bad_bus  $error("bus too narrow"); end
   endgenerate

   tvc_state_t state;
   logic signed [TW-1:0] temp_r, t_q, t_cl;
   logic [IW-1:0]        isc_r;
   logic [VW-1:0]        vcur_r, margin_r, cand_q, tgt_q, poly_code;
   logic signed [CW-1:0] pc [4];
   logic signed [CW-1:0] sa_r, sb_r, sg_r;
   logic [CW-1:0]        lk_r;
   logic                 ie_r, done_r, sw_r, go_q, poly_vld, ramp_fin;
   logic                 wr, start_w, busy;
   logic signed [SW-1:0] sav_cand, sav_cur, loss_q, vc_s, vp_s;

   assign pready  = 1'b1;
   assign wr      = psel && penable && pwrite;
   assign busy    = (state != ST_IDLE);
   assign start_w = wr && (paddr == AW'(OFF_CTRL)) && pwdata[0] && !busy;
   assign irq     = done_r && ie_r;
   assign t_cl    = (temp_r < T_LO) ? T_LO : ((temp_r > T_HI) ? T_HI : temp_r);

   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
         temp_r <= '0; isc_r <= '0; vcur_r <= VW'(VMAX); margin_r <= '0;
         sa_r <= '0; sb_r <= '0; sg_r <= '0; lk_r <= '0; ie_r <= 1'b0;
         for (int i = 0; i < 4; i++) pc[i] <= '0;
      end else if (wr) begin
         case (paddr)
            AW'(OFF_CTRL):   ie_r     <= pwdata[1];
            AW'(OFF_TEMP):   temp_r   <= pwdata[TW-1:0];
            AW'(OFF_ISC):    isc_r    <= pwdata[IW-1:0];
            AW'(OFF_VCUR):   vcur_r   <= pwdata[VW-1:0];
            AW'(OFF_MARGIN): margin_r <= pwdata[VW-1:0];
            AW'(OFF_SA):     sa_r     <= pwdata[CW-1:0];
            AW'(OFF_SB):     sb_r     <= pwdata[CW-1:0];
            AW'(OFF_SG):     sg_r     <= pwdata[CW-1:0];
            AW'(OFF_LK):     lk_r     <= pwdata[CW-1:0];
            default: begin
               for (int i = 0; i < 4; i++)
                  if (paddr == AW'(OFF_POLY + 8'(4*i))) pc[i] <= pwdata[CW-1:0];
            end
         endcase
      end
   end

   always_comb begin
      prdata = '0;
      if (psel) begin
         case (paddr)
            AW'(OFF_CTRL):   prdata = DW'({ie_r, 1'b0});
            AW'(OFF_STAT):   prdata = DW'({sw_r, done_r, busy});
            AW'(OFF_TEMP):   prdata = DW'({temp_r});
            AW'(OFF_ISC):    prdata = DW'(isc_r);
            AW'(OFF_VCUR):   prdata = DW'(vcur_r);
            AW'(OFF_VCMD):   prdata = DW'(vdd_cmd);
            AW'(OFF_MARGIN): prdata = DW'(margin_r);
            AW'(OFF_SA):     prdata = DW'({sa_r});
            AW'(OFF_SB):     prdata = DW'({sb_r});
            AW'(OFF_SG):     prdata = DW'({sg_r});
            AW'(OFF_LK):     prdata = DW'(lk_r);
            default: begin
               for (int i = 0; i < 4; i++)
                  if (paddr == AW'(OFF_POLY + 8'(4*i))) prdata = DW'({pc[i]});
            end
         endcase
      end
   end

   // linear saving model at the candidate and at the present code
   always_comb begin
      vc_s     = SW'(cand_q);
      vp_s     = SW'(vcur_r);
      sav_cand = SW'(sa_r) + SW'(sb_r) * SW'(t_q) - SW'(sg_r) * vc_s;
      sav_cur  = SW'(sa_r) + SW'(sb_r) * SW'(t_q) - SW'(sg_r) * vp_s;
   end

   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
         state <= ST_IDLE; t_q <= '0; cand_q <= '0; tgt_q <= '0; loss_q <= '0;
         done_r <= 1'b0; sw_r <= 1'b0; go_q <= 1'b0;
      end else begin
         go_q <= 1'b0;
         if (wr && (paddr == AW'(OFF_STAT))) done_r <= 1'b0;
         case (state)
            ST_IDLE: if (start_w) begin t_q <= t_cl; state <= ST_EVAL; end
            ST_EVAL: if (poly_vld) begin cand_q <= poly_code; state <= ST_CMP1; end
            ST_CMP1: begin
               if (cand_q > vcur_r) begin
                  tgt_q <= cand_q; sw_r <= 1'b1; go_q <= 1'b1; state <= ST_RAMP;
               end else if ((cand_q < vcur_r) && (sav_cand > sav_cur)) begin
                  state <= ST_LOSS;
               end else begin
                  tgt_q <= vcur_r; sw_r <= 1'b0; go_q <= 1'b1; state <= ST_RAMP;
               end
            end
            ST_LOSS: begin
               loss_q <= SW'(lk_r) * SW'(isc_r) * vc_s;
               state  <= ST_CMP2;
            end
            ST_CMP2: begin
               sw_r  <= (sav_cand - loss_q > sav_cur);
               tgt_q <= (sav_cand - loss_q > sav_cur) ? cand_q : vcur_r;
               go_q  <= 1'b1;
               state <= ST_RAMP;
            end
            ST_RAMP: if (ramp_fin) state <= ST_DONE;
            ST_DONE: begin done_r <= 1'b1; state <= ST_IDLE; end
            default: state <= ST_IDLE;
         endcase
      end
   end

   tvc_poly #(.TW(TW), .CW(CW), .VW(VW), .FRAC(FRAC), .VMIN(VMIN), .VMAX(VMAX)) u_poly (
      .clk(pclk), .rst_n(presetn), .go(start_w), .t(t_q), .coef(pc),
      .vld(poly_vld), .code(poly_code));

   tvc_ramp #(.VW(VW), .VRST(VMAX), .HOLD(HOLD)) u_ramp (
      .clk(pclk), .rst_n(presetn), .go(go_q), .cur(vcur_r), .tgt(tgt_q),
      .margin(margin_r), .cmd(vdd_cmd), .fin(ramp_fin));
endmodule

// File: rtl/tvc_ctrl_chk.sv
module tvc_ctrl_chk #(
   parameter int VW   = 5,
   parameter int VMIN = 8,
   parameter int VMAX = 14
) (
   input logic                clk,
   input logic                rst_n,
   input logic [VW-1:0]       cmd,
   input logic [VW-1:0]       cand,
   input logic                busy,
   input logic                go,
   input logic                done,
   input tvc_pkg::tvc_state_t state
);
   import tvc_pkg::*;

   assert_cmd_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd >= VW'(VMIN)) && (cmd <= VW'(VMAX)));

   assert_unit_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(go) && (cmd < $past(cmd))) |-> (cmd == $past(cmd) - VW'(1)));

   assert_safe_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE) |-> (cmd >= cand));

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cmd) |-> $past(busy));

   assert_done_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(state) == ST_DONE));
endmodule

bind tvc_ctrl tvc_ctrl_chk #(.VW(VW), .VMIN(VMIN), .VMAX(VMAX)) u_chk (
   .clk(pclk), .rst_n(presetn), .cmd(vdd_cmd), .cand(cand_q), .busy(busy),
   .go(go_q), .done(done_r), .state(state));

// File: tb/tvc_ctrl_tb.sv
`timescale 1ns/1ps
module tvc_ctrl_tb;
   localparam int HOLD = 4;
   localparam int VMIN = 8;
   localparam int VMAX = 14;

   logic pclk = 1'b0, presetn = 1'b0;
   logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [7:0] paddr = '0;
   logic [31:0] pwdata = '0, prdata;
   logic pready, irq;
   logic [4:0] vdd_cmd;

   int total = 0, bad = 0;
   longint c0, c1, c2, c3, sa, sb, sg, lk;
   int margin = 2;
   bit ie = 0;

   // ramp monitor
   bit trk = 0, got_first = 0, timed = 0;
   int last_v = 0, cyc = 0, mon_bad = 0, min_v = 99, exp_first = 0;

   always #4 pclk = ~pclk;

   tvc_ctrl #(.HOLD(HOLD)) u_dut (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
      .vdd_cmd(vdd_cmd), .irq(irq));

   always @(negedge pclk) begin
      if (trk) begin
         if (int'(vdd_cmd) != last_v) begin
            if (!got_first && int'(vdd_cmd) == exp_first) begin
               got_first = 1; timed = 1;
            end else if (int'(vdd_cmd) == last_v - 1) begin
               if (timed && cyc != HOLD - 1) mon_bad++;
            end else mon_bad++;
            if (int'(vdd_cmd) < min_v) min_v = int'(vdd_cmd);
            last_v = int'(vdd_cmd);
            cyc = 0;
         end else cyc++;
      end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
      @(negedge pclk); penable = 1;
      @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
      @(negedge pclk); penable = 1; d = prdata;
      @(negedge pclk); psel = 0; penable = 0;
   endtask

   task automatic load_set(input longint p0, p1, p2, p3, a, b, g, k);
      c0 = p0; c1 = p1; c2 = p2; c3 = p3; sa = a; sb = b; sg = g; lk = k;
      apb_wr(8'h1C, 32'(p0)); apb_wr(8'h20, 32'(p1));
      apb_wr(8'h24, 32'(p2)); apb_wr(8'h28, 32'(p3));
      apb_wr(8'h2C, 32'(a));  apb_wr(8'h30, 32'(b));
      apb_wr(8'h34, 32'(g));  apb_wr(8'h38, 32'(k));
   endtask

   function automatic longint clampt(input int t);
      return (t < -40) ? -40 : ((t > 80) ? 80 : t);
   endfunction

   function automatic int cand_of(input int t);
      longint tc, acc, r;
      tc  = clampt(t);
      acc = c3*tc*tc*tc + c2*tc*tc + c1*tc + c0;
      r   = (acc + 63) >>> 6;
      if (r < VMIN) r = VMIN;
      if (r > VMAX) r = VMAX;
      return int'(r);
   endfunction

   function automatic longint sav(input int t, input int v);
      return sa + sb*clampt(t) - sg*v;
   endfunction

   task automatic wait_done();
      logic [31:0] s;
      int n = 0;
      s = 0;
      while (!s[1] && n < 300) begin apb_rd(8'h04, s); n++; end
      if (!s[1]) chk("R9 done-timeout", 0, 1);
   endtask

   task automatic run_dec(input int t, input int isc, input int vcur, output int act_v, output int exp_v);
      int cand, fin, swx;
      string tag;
      logic [31:0] s;
      cand = cand_of(t);
      if (cand > vcur) begin fin = cand; swx = 1; tag = "R4"; end
      else if (cand == vcur) begin fin = vcur; swx = 0; tag = "R5"; end
      else if (!(sav(t, cand) > sav(t, vcur))) begin fin = vcur; swx = 0; tag = "R6"; end
      else if (sav(t, cand) - lk*isc*cand > sav(t, vcur)) begin fin = cand; swx = 1; tag = "R7"; end
      else begin fin = vcur; swx = 0; tag = "R7"; end
      exp_first = (swx == 1 && cand < vcur) ? ((cand + margin > vcur) ? vcur : cand + margin) : fin;
      apb_wr(8'h04, 0);
      apb_wr(8'h08, 32'(t));
      apb_wr(8'h0C, 32'(isc));
      apb_wr(8'h10, 32'(vcur));
      last_v = int'(vdd_cmd); min_v = 99; mon_bad = 0; cyc = 0; timed = 0;
      got_first = (int'(vdd_cmd) == exp_first);
      trk = 1;
      apb_wr(8'h00, {30'd0, ie, 1'b1});
      wait_done();
      trk = 0;
      apb_rd(8'h14, s);
      act_v = int'(s[4:0]); exp_v = fin;
      chk({"R3 ", tag, " final code"}, act_v, fin);
      apb_rd(8'h04, s);
      chk("R9 switched flag", s[2], swx);
      chk("R8 ramp shape", (mon_bad == 0 && got_first && (min_v == 99 || min_v >= fin)) ? 1 : 0, 1);
   endtask

   initial begin
      repeat (150000) @(posedge pclk);
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] r;
      int a, e, a2, e2;
      repeat (4) @(negedge pclk);
      presetn = 1;
      // R1 reset state
      apb_rd(8'h04, r); chk("R1 status reset", r, 0);
      apb_rd(8'h14, r); chk("R1 vcmd reset", r, VMAX);
      chk("R1 port reset", vdd_cmd, VMAX);
      chk("R10 irq reset", irq, 0);
      // R1 readback
      apb_wr(8'h18, margin);  apb_rd(8'h18, r); chk("R1 margin readback", r, margin);
      apb_wr(8'h08, 32'hFFFF_FFFB); apb_rd(8'h08, r); chk("R1 temp readback", r, 32'hFB);
      apb_wr(8'h20, 32'hFFFF_FFFF); apb_rd(8'h20, r); chk("R1 coef readback", r, 32'hFFFF);
      // R11 idle writes do not move the output
      apb_wr(8'h10, 9); apb_wr(8'h08, 20); repeat (10) @(negedge pclk);
      chk("R11 idle hold", vdd_cmd, VMAX);

      // sweeps over three coefficient sets
      for (int set = 0; set < 3; set++) begin
         if (set == 0)      load_set(672, -1, 0, 0, 1000, 5, 60, 1);
         else if (set == 1) load_set(900, -60, 1, 0, 1000, 5, -10, 1);
         else               load_set(700, 0, 0, -1, 1000, 5, 60, 1);
         for (int t = -40; t <= 80; t += 8)
            for (int v = VMIN; v <= VMAX; v++)
               run_dec(t, (v * 7 + t) % 3 == 0 ? 0 : ((v % 2) ? 5 : 200), v, a, e);
      end

      // R2 temperature clamping, compared to the range ends
      load_set(672, -1, 0, 0, 1000, 5, 60, 1);
      run_dec(100, 0, 14, a, e);  run_dec(80, 0, 14, a2, e2);
      chk("R2 clamp high", a, e2);
      run_dec(-100, 0, 8, a, e); run_dec(-40, 0, 8, a2, e2);
      chk("R2 clamp low", a, e2);

      // R9 busy and start while busy ignored
      apb_wr(8'h04, 0);
      apb_wr(8'h10, 14); apb_wr(8'h0C, 0); apb_wr(8'h08, 32'(-40));
      apb_wr(8'h00, 1);
      apb_rd(8'h04, r); chk("R9 busy after start", r[0], 1);
      apb_wr(8'h08, 80); apb_wr(8'h00, 1);
      wait_done();
      repeat (80) @(negedge pclk);
      apb_rd(8'h14, r); chk("R9 restart ignored", r, cand_of(-40));
      apb_rd(8'h04, r); chk("R9 idle after done", r[0], 0);

      // R10 interrupt
      ie = 1;
      run_dec(40, 0, 14, a, e);
      chk("R10 irq set", irq, 1);
      apb_wr(8'h04, 0);
      chk("R10 irq cleared", irq, 0);
      apb_rd(8'h04, r); chk("R10 done cleared", r[1], 0);
      ie = 0;
      apb_wr(8'h00, 0);
      run_dec(40, 0, 14, a, e);
      chk("R10 irq masked", irq, 0);

      // R11 after a decision, idle writes still leave the output alone
      apb_wr(8'h10, 8); apb_wr(8'h18, 0); repeat (10) @(negedge pclk);
      chk("R11 idle hold after run", vdd_cmd, e);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule